// File: doc/BRIEF.md
# Legacy INTx Message Generator

This block turns a vector of application interrupt status lines into a stream of legacy INTA assert and deassert message requests for a PCIe transmit path. It ORs all status bits into one interrupt level and gates that level with two configuration bits: the command register's interrupt-disable bit and the MSI enable bit. Legacy signalling counts as permitted only while both bits are clear.

The block remembers the state it last signalled. Whenever the gated level differs from that state, it raises one message request toward the new state. A request stays on a valid/ready handshake until it is accepted. Level changes that arrive while a request waits are resolved against the latest level once the handshake frees up, so assert and deassert requests always alternate.

Top module: `intx_msg_gen`

## Requirements
- R1: After reset, `msgValid` is low and the signalled state is deasserted. A nonzero status with signalling permitted therefore produces an assert request on the first cycle after reset release.
- R2: The interrupt level is the OR of all status bits. When it goes from zero to nonzero while signalling is permitted, exactly one request with `msgAssert`=1 is raised, visible one clock edge after the change.
- R3: A change between two nonzero status patterns produces no request.
- R4: When the level goes from nonzero to zero while asserted, exactly one request with `msgAssert`=0 is raised.
- R5: While `cmdIntDisable` is 1, no assert request is raised, whatever the status.
- R6: While `msiEnable` is 1, no assert request is raised. When it clears while the level is nonzero, an assert request follows.
- R7: If signalling stops being permitted while the state is asserted, one deassert request is raised.
- R8: While `msgValid` is 1 and `msgReady` is 0, `msgValid` stays 1 and `msgAssert` keeps its value.
- R9: Level changes during a stall are settled after acceptance against the latest gated level. A level that drops and returns during the stall adds no request.
- R10: Two requests accepted in a row never carry the same `msgAssert` value.
- R11: In the cycle a request is accepted, a new request of the opposite kind is loaded if the gated level still differs from the signalled state. There is no idle cycle between the two requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intStsVec | input | 8 | Application interrupt status lines |
| cmdIntDisable | input | 1 | Interrupt-disable bit from the command register |
| msiEnable | input | 1 | MSI enable bit |
| msgReady | input | 1 | Transmit path accepts the pending request |
| msgValid | output | 1 | A message request is pending |
| msgAssert | output | 1 | 1 = assert message, 0 = deassert message |

## Verification
The status vector is driven with single-bit, multi-bit and bit-swapping patterns. These show whether the block follows the combined level or individual bits. The two gating bits are toggled both while the level is idle and while it is asserted, which separates suppression from forced deassertion. Stalls on `msgReady` with glitches and net changes in the level underneath tell settling against the latest level apart from queueing every edge. A long pseudo-random run mixes all inputs against the cycle model.

// File: rtl/intx_pkg.sv
package intx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic issue;   // load a new request, kind = gated level
    logic retire;  // drop the accepted request
  } intx_strobe_t;
endpackage

// File: rtl/intx_level_dp.sv
module intx_level_dp
  import intx_pkg::*;
#(
  parameter int STS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [STS_W-1:0] stsVec,
  input  logic             intDisable,
  input  logic             msiOn,
  input  intx_strobe_t     strobe,
  output logic             wantAsserted,
  output logic             assertedQ,
  output logic             validQ,
  output logic             kindQ
);
  localparam int LAST = STS_W - 1;

  logic [LAST:0] orChain;
  logic          permit;

  // Ripple OR of status bits
  genvar gi;
  generate
    for (gi = 0; gi < STS_W; gi++) begin : g_or
      if (gi == 0) begin : g_first
        assign orChain[gi] = stsVec[gi];
      end else begin : g_rest
        assign orChain[gi] = orChain[gi-1] | stsVec[gi];
      end
    end
  endgenerate

  assign permit       = !intDisable && !msiOn;
  assign wantAsserted = permit && orChain[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      assertedQ <= 1'b0;
      validQ    <= 1'b0;
      kindQ     <= 1'b0;
    end else if (strobe.issue) begin
      validQ    <= 1'b1;
      kindQ     <= wantAsserted;
      assertedQ <= wantAsserted;
    end else if (strobe.retire) begin
      validQ    <= 1'b0;
    end
  end

  // R5: a request loaded while disabled is a deassert
  p_disable_no_assert_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (intDisable && strobe.issue) |=> !kindQ);
  // R6: a request loaded while MSI is on is a deassert
  p_msi_no_assert_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (msiOn && strobe.issue) |=> !kindQ);
  // R3: with the flag and a nonzero level both held, nothing changes
  p_steady_flag_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (assertedQ && wantAsserted) |=> assertedQ);
endmodule

// File: rtl/intx_ctrl.sv
module intx_ctrl
  import intx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wantAsserted,
  input  logic         assertedQ,
  input  logic         validQ,
  input  logic         kindQ,
  input  logic         ready,
  output intx_strobe_t strobe
);
  logic slotFree;
  logic differs;

  assign slotFree = !validQ || ready;
  assign differs  = wantAsserted != assertedQ;

  always_comb begin
    strobe        = '0;
    strobe.issue  = slotFree && differs;
    strobe.retire = validQ && ready && !differs;
  end

  // R8: a stalled request holds
  p_hold_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !ready) |=> (validQ && $stable(kindQ)));
  // R10: consecutive requests alternate
  p_alternate_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (validQ && ready) |=> (!validQ || (kindQ != $past(kindQ))));
  // R3: nothing to report means no request
  p_quiet_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (!validQ && !differs) |=> !validQ);
  // R2: a new nonzero level while idle gives an assert
  p_rise_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (!validQ && wantAsserted && !assertedQ) |=> (validQ && kindQ));
  // R11: accept with a pending difference reloads at once
  p_backtoback_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (validQ && ready && differs) |=> validQ);
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen
  import intx_pkg::*;
#(
  parameter int STS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [STS_W-1:0] intStsVec,
  input  logic             cmdIntDisable,
  input  logic             msiEnable,
  input  logic             msgReady,
  output logic             msgValid,
  output logic             msgAssert
);
  intx_strobe_t strobe;
  logic wantAsserted;
  logic assertedQ;

  intx_level_dp #(.STS_W(STS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stsVec       (intStsVec),
    .intDisable   (cmdIntDisable),
    .msiOn        (msiEnable),
    .strobe       (strobe),
    .wantAsserted (wantAsserted),
    .assertedQ    (assertedQ),
    .validQ       (msgValid),
    .kindQ        (msgAssert)
  );

  intx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wantAsserted (wantAsserted),
    .assertedQ    (assertedQ),
    .validQ       (msgValid),
    .kindQ        (msgAssert),
    .ready        (msgReady),
    .strobe       (strobe)
  );

  // R1: idle out of reset
  p_reset_idle_r1 : assert property (@(posedge clk)
    !rstN |=> !msgValid);
endmodule

// File: tb/sim_intx_msg_gen.sv
`timescale 1ns/1ps
module sim_intx_msg_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] intStsVec = '0;
  logic       cmdIntDisable = 1'b0;
  logic       msiEnable = 1'b0;
  logic       msgReady = 1'b1;
  logic       msgValid;
  logic       msgAssert;

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R1";
  bit    done    = 1'b0;

  // Reference model state
  bit mValid = 0, mKind = 0, mState = 0;
  int sent[$];  // kinds of accepted requests

  always #2.5 clk = ~clk;

  intx_msg_gen u0 (
    .clk(clk), .rstN(rstN), .intStsVec(intStsVec),
    .cmdIntDisable(cmdIntDisable), .msiEnable(msiEnable),
    .msgReady(msgReady), .msgValid(msgValid), .msgAssert(msgAssert)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: one request slot, last signalled level
  always @(posedge clk) begin
    if (!rstN) begin
      mValid = 0; mKind = 0; mState = 0;
    end else begin
      bit lvl;
      lvl = (intStsVec != 0) && !cmdIntDisable && !msiEnable;
      if (mValid && msgReady) begin
        sent.push_back(mKind);
        mValid = 0;
      end
      if (!mValid && lvl != mState) begin
        mValid = 1; mKind = lvl; mState = lvl;
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({phase, " valid"}, msgValid, mValid);
      if (mValid) check({phase, " kind"}, msgAssert, mKind);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset valid", msgValid, 0);
    // R2: single bit rises
    phase = "R2"; intStsVec = 8'h04;
    @(negedge clk);
    check("R2 assert raised", msgValid, 1);
    check("R2 assert kind", msgAssert, 1);
    @(negedge clk);
    check("R2 exactly one", msgValid, 0);
    // R3: nonzero pattern swaps
    phase = "R3"; intStsVec = 8'h81; cyc(2); intStsVec = 8'h10; cyc(2);
    check("R3 no message", msgValid, 0);
    // R4: level falls
    phase = "R4"; intStsVec = 8'h00;
    @(negedge clk);
    check("R4 deassert raised", msgValid, 1);
    check("R4 deassert kind", msgAssert, 0);
    cyc(2);
    // R5: disabled
    phase = "R5"; cmdIntDisable = 1; intStsVec = 8'hFF; cyc(3);
    check("R5 suppressed", msgValid, 0);
    intStsVec = 8'h00; cyc(2); cmdIntDisable = 0; cyc(2);
    // R6: MSI on, then off with level high
    phase = "R6"; msiEnable = 1; intStsVec = 8'h01; cyc(3);
    check("R6 suppressed", msgValid, 0);
    msiEnable = 0;
    @(negedge clk);
    check("R6 assert after MSI off", msgAssert, 1);
    intStsVec = 8'h00; cyc(3);
    // R7: disable while asserted
    phase = "R7"; intStsVec = 8'h02; cyc(2); cmdIntDisable = 1;
    @(negedge clk);
    check("R7 forced deassert", msgValid, 1);
    check("R7 forced deassert kind", msgAssert, 0);
    cyc(2); cmdIntDisable = 0; cyc(3);
    // R8: stall a deassert
    phase = "R8"; msgReady = 0; intStsVec = 8'h00; cyc(4);
    check("R8 held valid", msgValid, 1);
    check("R8 held kind", msgAssert, 0);
    // R9: glitch during stall, net result high
    phase = "R9"; intStsVec = 8'h20; cyc(1); intStsVec = 8'h00; cyc(1);
    intStsVec = 8'h08; cyc(1);
    phase = "R11"; msgReady = 1;
    @(negedge clk);
    check("R11 back-to-back assert", msgAssert, 1);
    check("R11 back-to-back valid", msgValid, 1);
    @(negedge clk);
    check("R9 settled, no extra", msgValid, 0);
    // R9: stall an assert, level drops and returns
    intStsVec = 8'h00; cyc(2); msgReady = 0; intStsVec = 8'h40; cyc(1);
    intStsVec = 8'h00; cyc(1); intStsVec = 8'h40; cyc(2); msgReady = 1; cyc(1);
    cyc(1);
    check("R9 glitch absorbed", msgValid, 0);
    // R10: pseudo-random mix
    phase = "R10";
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 2000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        intStsVec     = (lfsr[3:0] < 6) ? 8'h00 : lfsr[15:8];
        cmdIntDisable = (lfsr[6:4] == 3'd0);
        msiEnable     = (lfsr[7:5] == 3'd7);
        msgReady      = lfsr[1] | lfsr[9];
        @(negedge clk);
      end
    end
    begin
      int bad = 0;
      for (int i = 1; i < sent.size(); i++)
        if (sent[i] == sent[i-1]) bad++;
      check("R10 accepted kinds alternate", bad, 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule